// File: doc/BRIEF.md
# Floating-Point Special-Case Resolver

This block is the final stage of a binary64 add/subtract pipeline. It receives the two original operands, the operation select, the rounding mode, and the rounded word from the rounder. It also receives that stage's two leftover remainder bits and its overflow and underflow indications. It inspects the operands for NaN and infinity and applies a fixed priority among the special conditions. It then either passes the rounded word through or replaces it with the proper special value.

The final word and five status flags are registered together. A one-cycle ready pulse marks them valid in the cycle after the request. When an infinite result meets a directed rounding mode that must not reach infinity, the block also clamps the result to the largest finite value.

Top module: `fpx_special_unit`

## Requirements
- R1: Each cycle with `in_valid` high produces `out_ready` high in the next cycle only, with `out_result` and all flags updated in that same cycle; otherwise the result and flags hold and `out_ready` is low. Reset (synchronous, active high) clears every output to zero.
- R2: An operand is NaN when its exponent field is all ones and its fraction is nonzero. It is quiet when fraction bit 51 is one and signaling when that bit is zero. An all-ones exponent with a zero fraction is infinity.
- R3: If operand A is a signaling NaN, the output is A with fraction bit 51 set. Otherwise, if B is a signaling NaN, the output is B with that bit set. Both cases raise invalid and exception, and this check outranks every other condition.
- R4: With no signaling NaN present, a quiet NaN in A is output unchanged; otherwise a quiet NaN in B is output unchanged. Exception is raised and invalid is not.
- R5: With no NaN present, two infinite operands under an effective subtraction produce the generated signaling NaN 0x7FF0000000000001 and raise invalid and exception. Effective subtraction means add (`op_sub`=0) with differing signs, or subtract (`op_sub`=1) with equal signs.
- R6: With no NaN or infinite operand, `rnd_ovf` gives an infinity carrying bit 63 of `rnd_result`, and raises overflow and exception. Overflow, underflow and invalid are never raised together.
- R7: With no NaN or infinite operand and no `rnd_ovf`, `rnd_unf` gives a zero carrying bit 63 of `rnd_result`, and raises underflow and exception.
- R8: With no NaN and no cancelling infinities, an infinite operand gives an infinity and raises exception, but neither overflow nor invalid. Its sign is A's sign if A is infinite, otherwise B's sign inverted when `op_sub`=1.
- R9: A positive infinity from R6, R8 or R11 becomes 0x7FEFFFFFFFFFFFFF in mode 01 (toward zero) or 11 (toward minus). A negative one becomes 0xFFEFFFFFFFFFFFFF in mode 01 or 10 (toward plus). Mode 00 (nearest) keeps infinity.
- R10: Inexact equals the OR of the two `rnd_rem` bits on every request, whatever path is taken.
- R11: When none of R3 to R8 applies, `rnd_result` is output, subject only to R9. Overflow, underflow, invalid and exception are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request: all other inputs are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (A minus B) |
| rnd_mode | input | 2 | 00 nearest, 01 toward zero, 10 toward plus, 11 toward minus |
| opnd_a | input | 64 | Original operand A |
| opnd_b | input | 64 | Original operand B |
| rnd_result | input | 64 | Rounded word from the rounding stage |
| rnd_rem | input | 2 | Remainder bits from the rounding stage |
| rnd_ovf | input | 1 | Rounding stage reports exponent overflow |
| rnd_unf | input | 1 | Rounding stage reports underflow |
| out_result | output | 64 | Final registered result |
| out_ready | output | 1 | One-cycle pulse: result and flags valid |
| flag_underflow | output | 1 | Underflow flag |
| flag_overflow | output | 1 | Overflow flag |
| flag_inexact | output | 1 | Inexact flag |
| flag_exception | output | 1 | Any special case detected |
| flag_invalid | output | 1 | Invalid operation |

## Verification
The bench crosses seven operand kinds for each operand: zero, two finite values, both infinities, a quiet NaN and a signaling NaN, with distinct payloads for A and B. It applies both operations, all four rounding modes, every overflow/underflow combination, every remainder pattern, and three rounded words, one of them infinite. Pairing NaN kinds separates signaling-over-quiet and A-over-B precedence. Pairing infinities separates cancelling from non-cancelling sums. Finite operands with the overflow and underflow indications separate the two saturation directions in each mode and show that overflow outranks underflow.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic sign;
    logic is_inf;
    logic is_qnan;
    logic is_snan;
  } opclass_t;

endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word_i,
  output opclass_t          cls_o
);

  logic exp_max;
  logic frac_zero;

  assign exp_max   = &word_i[WORD_W-2:FRAC_W];
  assign frac_zero = (word_i[FRAC_W-1:0] == '0);

  always_comb begin
    cls_o.sign    = word_i[WORD_W-1];
    cls_o.is_inf  = exp_max & frac_zero;
    cls_o.is_qnan = exp_max & ~frac_zero & word_i[FRAC_W-1];
    cls_o.is_snan = exp_max & ~frac_zero & ~word_i[FRAC_W-1];
  end

endmodule

// File: rtl/fpx_select.sv
module fpx_select
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  opclass_t          cls_a,
  input  opclass_t          cls_b,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic              op_sub,
  input  logic [WORD_W-1:0] rnd_result,
  input  logic              rnd_ovf,
  input  logic              rnd_unf,
  output logic [WORD_W-1:0] pre_result,
  output logic              sat_en,
  output logic              f_inv,
  output logic              f_ovf,
  output logic              f_unf,
  output logic              f_exc
);

  localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);
  localparam logic [WORD_W-1:0] GEN_SNAN  =
    {1'b0, {EXP_W{1'b1}}, {(FRAC_W-1){1'b0}}, 1'b1};
  localparam logic [WORD_W-2:0] INF_MAG   = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic eff_sub;
  logic b_sign_eff;

  assign b_sign_eff = cls_b.sign ^ op_sub;
  assign eff_sub    = cls_a.sign ^ b_sign_eff;

  always_comb begin
    pre_result = rnd_result;
    sat_en     = 1'b0;
    f_inv      = 1'b0;
    f_ovf      = 1'b0;
    f_unf      = 1'b0;
    f_exc      = 1'b0;
    if (cls_a.is_snan) begin
      pre_result = opnd_a | QUIET_BIT;
      f_inv      = 1'b1;
      f_exc      = 1'b1;
    end else if (cls_b.is_snan) begin
      pre_result = opnd_b | QUIET_BIT;
      f_inv      = 1'b1;
      f_exc      = 1'b1;
    end else if (cls_a.is_qnan) begin
      pre_result = opnd_a;
      f_exc      = 1'b1;
    end else if (cls_b.is_qnan) begin
      pre_result = opnd_b;
      f_exc      = 1'b1;
    end else if (cls_a.is_inf && cls_b.is_inf && eff_sub) begin
      pre_result = GEN_SNAN;
      f_inv      = 1'b1;
      f_exc      = 1'b1;
    end else if (cls_a.is_inf || cls_b.is_inf) begin
      pre_result = {(cls_a.is_inf ? cls_a.sign : b_sign_eff), INF_MAG};
      sat_en     = 1'b1;
      f_exc      = 1'b1;
    end else if (rnd_ovf) begin
      pre_result = {rnd_result[WORD_W-1], INF_MAG};
      sat_en     = 1'b1;
      f_ovf      = 1'b1;
      f_exc      = 1'b1;
    end else if (rnd_unf) begin
      pre_result = {rnd_result[WORD_W-1], {(WORD_W-1){1'b0}}};
      f_unf      = 1'b1;
      f_exc      = 1'b1;
    end else begin
      sat_en     = 1'b1;
    end
  end

endmodule

// File: rtl/fpx_saturate.sv
module fpx_saturate
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] pre_result,
  input  logic              sat_en,
  input  rmode_e            rnd_mode,
  output logic [WORD_W-1:0] result
);

  localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-2:0] MAX_MAG = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

  logic is_inf;
  logic clamp;

  assign is_inf = sat_en && (pre_result[WORD_W-2:0] == INF_MAG);

  always_comb begin
    if (pre_result[WORD_W-1])
      clamp = is_inf && (rnd_mode == RM_ZERO || rnd_mode == RM_UP);
    else
      clamp = is_inf && (rnd_mode == RM_ZERO || rnd_mode == RM_DOWN);
    result = clamp ? {pre_result[WORD_W-1], MAX_MAG} : pre_result;
  end

endmodule

// File: rtl/fpx_special_unit.sv
module fpx_special_unit
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [1:0]        rnd_mode,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [WORD_W-1:0] rnd_result,
  input  logic [1:0]        rnd_rem,
  input  logic              rnd_ovf,
  input  logic              rnd_unf,
  output logic [WORD_W-1:0] out_result,
  output logic              out_ready,
  output logic              flag_underflow,
  output logic              flag_overflow,
  output logic              flag_inexact,
  output logic              flag_exception,
  output logic              flag_invalid
);

  localparam int NUM_OPND = 2;

  logic [WORD_W-1:0] opnd_vec [NUM_OPND];
  opclass_t          cls      [NUM_OPND];
  logic [WORD_W-1:0] pre_result;
  logic [WORD_W-1:0] sat_result;
  logic              sat_en;
  logic              f_inv, f_ovf, f_unf, f_exc;

  assign opnd_vec[0] = opnd_a;
  assign opnd_vec[1] = opnd_b;

  for (genvar gi = 0; gi < NUM_OPND; gi++) begin : g_cls
    fpx_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word_i (opnd_vec[gi]),
      .cls_o  (cls[gi])
    );
  end

  fpx_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
    .cls_a      (cls[0]),
    .cls_b      (cls[1]),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .op_sub     (op_sub),
    .rnd_result (rnd_result),
    .rnd_ovf    (rnd_ovf),
    .rnd_unf    (rnd_unf),
    .pre_result (pre_result),
    .sat_en     (sat_en),
    .f_inv      (f_inv),
    .f_ovf      (f_ovf),
    .f_unf      (f_unf),
    .f_exc      (f_exc)
  );

  fpx_saturate #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sat (
    .pre_result (pre_result),
    .sat_en     (sat_en),
    .rnd_mode   (rmode_e'(rnd_mode)),
    .result     (sat_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_result     <= '0;
      out_ready      <= 1'b0;
      flag_underflow <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_inexact   <= 1'b0;
      flag_exception <= 1'b0;
      flag_invalid   <= 1'b0;
    end else begin
      out_ready <= in_valid;
      if (in_valid) begin
        out_result     <= sat_result;
        flag_underflow <= f_unf;
        flag_overflow  <= f_ovf;
        flag_inexact   <= |rnd_rem;
        flag_exception <= f_exc;
        flag_invalid   <= f_inv;
      end
    end
  end

endmodule

// File: rtl/fpx_special_unit_chk.sv
module fpx_special_unit_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        rnd_mode,
  input logic [1:0]        rnd_rem,
  input logic              rnd_ovf,
  input logic [WORD_W-1:0] out_result,
  input logic              out_ready,
  input logic              flag_underflow,
  input logic              flag_overflow,
  input logic              flag_inexact,
  input logic              flag_exception,
  input logic              flag_invalid
);

  localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_ready); // R1
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_ready); // R1
  AST_INEXACT_REM: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flag_inexact == ($past(rnd_rem) != 2'b00))); // R10
  AST_INVALID_EXC: assert property (@(posedge clk) disable iff (rst)
    flag_invalid |-> flag_exception); // R3
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_overflow, flag_underflow, flag_invalid})); // R6
  AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (rst)
    in_valid && !rnd_ovf |=> !flag_overflow); // R6
  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst)
    flag_underflow |-> (out_result[WORD_W-2:0] == '0)); // R7
  AST_NO_INF_TOWARD_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && rnd_mode == 2'b01 |=> out_result[WORD_W-2:0] != INF_MAG); // R9

endmodule

bind fpx_special_unit fpx_special_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .rnd_mode       (rnd_mode),
  .rnd_rem        (rnd_rem),
  .rnd_ovf        (rnd_ovf),
  .out_result     (out_result),
  .out_ready      (out_ready),
  .flag_underflow (flag_underflow),
  .flag_overflow  (flag_overflow),
  .flag_inexact   (flag_inexact),
  .flag_exception (flag_exception),
  .flag_invalid   (flag_invalid)
);

// File: tb/fpx_special_unit_test.sv
`timescale 1ns/1ps
module fpx_special_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        op_sub;
  logic [1:0]  rnd_mode;
  logic [63:0] opnd_a, opnd_b, rnd_result;
  logic [1:0]  rnd_rem;
  logic        rnd_ovf, rnd_unf;
  logic [63:0] out_result;
  logic        out_ready;
  logic        flag_underflow, flag_overflow, flag_inexact, flag_exception, flag_invalid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fpx_special_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub), .rnd_mode(rnd_mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .rnd_result(rnd_result), .rnd_rem(rnd_rem),
    .rnd_ovf(rnd_ovf), .rnd_unf(rnd_unf), .out_result(out_result), .out_ready(out_ready),
    .flag_underflow(flag_underflow), .flag_overflow(flag_overflow),
    .flag_inexact(flag_inexact), .flag_exception(flag_exception), .flag_invalid(flag_invalid)
  );

  function automatic logic [63:0] pick_opnd(input int k, input bit is_b);
    case (k)
      0: return 64'h0000000000000000;
      1: return 64'h3FF8000000000000;
      2: return 64'hC000000000000000;
      3: return 64'h7FF0000000000000;
      4: return 64'hFFF0000000000000;
      5: return is_b ? 64'hFFF8000000000789 : 64'h7FF8000000000123;
      default: return is_b ? 64'hFFF0000000000ABC : 64'h7FF0000000000456;
    endcase
  endfunction

  function automatic logic [63:0] pick_rnd(input int k);
    case (k)
      0: return 64'h4008000000000000;
      1: return 64'hC000000000000001;
      default: return 64'h7FF0000000000000;
    endcase
  endfunction

  // Reference built from the requirement text; flags packed {unf, ovf, inx, exc, inv}
  task automatic expect_out(input logic [63:0] a, input logic [63:0] b, input logic sub,
                            input logic [1:0] mode, input logic [63:0] rr, input logic [1:0] rem,
                            input logic ovf, input logic unf,
                            output logic [63:0] res, output logic [4:0] fl, output string tag);
    bit a_nan, b_nan, a_q, b_q, a_inf, b_inf, bs, may_sat;
    bit unf_f, ovf_f, exc_f, inv_f;
    a_nan = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
    b_nan = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    a_q = a_nan && a[51];
    b_q = b_nan && b[51];
    a_inf = (a[62:52] == 11'h7FF) && (a[51:0] == 0);
    b_inf = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
    bs = b[63] ^ sub;
    unf_f = 0; ovf_f = 0; exc_f = 0; inv_f = 0; may_sat = 0;
    if (a_nan && !a_q) begin
      res = a | (64'd1 << 51); inv_f = 1; exc_f = 1; tag = "R3";
    end else if (b_nan && !b_q) begin
      res = b | (64'd1 << 51); inv_f = 1; exc_f = 1; tag = "R3";
    end else if (a_q) begin
      res = a; exc_f = 1; tag = "R4";
    end else if (b_q) begin
      res = b; exc_f = 1; tag = "R4";
    end else if (a_inf && b_inf && (a[63] != bs)) begin
      res = 64'h7FF0000000000001; inv_f = 1; exc_f = 1; tag = "R5";
    end else if (a_inf || b_inf) begin
      res = {(a_inf ? a[63] : bs), 63'h7FF0000000000000}; exc_f = 1; may_sat = 1; tag = "R8";
    end else if (ovf) begin
      res = {rr[63], 63'h7FF0000000000000}; ovf_f = 1; exc_f = 1; may_sat = 1; tag = "R6";
    end else if (unf) begin
      res = {rr[63], 63'h0}; unf_f = 1; exc_f = 1; tag = "R7";
    end else begin
      res = rr; may_sat = 1; tag = "R11";
    end
    if (may_sat && res == 64'h7FF0000000000000 && (mode == 2'b01 || mode == 2'b11)) begin
      res = 64'h7FEFFFFFFFFFFFFF; tag = {tag, "/R9"};
    end
    if (may_sat && res == 64'hFFF0000000000000 && (mode == 2'b01 || mode == 2'b10)) begin
      res = 64'hFFEFFFFFFFFFFFFF; tag = {tag, "/R9"};
    end
    fl = {unf_f, ovf_f, (rem != 2'b00), exc_f, inv_f};
    tag = {tag, "/R2/R10"};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] exp_res, held;
    logic [4:0]  exp_fl;
    string       tag;
    rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0; rnd_mode = 2'b00;
    opnd_a = '0; opnd_b = '0; rnd_result = '0; rnd_rem = '0; rnd_ovf = 1'b0; rnd_unf = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if ({out_result, out_ready, flag_underflow, flag_overflow, flag_inexact,
         flag_exception, flag_invalid} != '0) begin
      errors++;
      $display("FAIL R1 reset: actual %h rdy %b, expected all zero", out_result, out_ready);
    end
    rst = 1'b0;
    for (int ka = 0; ka < 7; ka++)
      for (int kb = 0; kb < 7; kb++)
        for (int so = 0; so < 2; so++)
          for (int md = 0; md < 4; md++)
            for (int ou = 0; ou < 4; ou++)
              for (int rm = 0; rm < 4; rm++)
                for (int rk = 0; rk < 3; rk++) begin
                  opnd_a = pick_opnd(ka, 1'b0);
                  opnd_b = pick_opnd(kb, 1'b1);
                  op_sub = so[0];
                  rnd_mode = md[1:0];
                  rnd_ovf = ou[1];
                  rnd_unf = ou[0];
                  rnd_rem = rm[1:0];
                  rnd_result = pick_rnd(rk);
                  in_valid = 1'b1;
                  expect_out(opnd_a, opnd_b, op_sub, rnd_mode, rnd_result, rnd_rem,
                             rnd_ovf, rnd_unf, exp_res, exp_fl, tag);
                  @(negedge clk);
                  checks++;
                  if (!out_ready || out_result != exp_res ||
                      {flag_underflow, flag_overflow, flag_inexact, flag_exception, flag_invalid} != exp_fl) begin
                    errors++;
                    $display("FAIL %s/R1: actual %h fl %b rdy %b, expected %h fl %b rdy 1",
                             tag, out_result,
                             {flag_underflow, flag_overflow, flag_inexact, flag_exception, flag_invalid},
                             out_ready, exp_res, exp_fl);
                  end
                  held = exp_res;
                  in_valid = 1'b0;
                  opnd_a = 64'h7FF0000000000001;
                  rnd_ovf = 1'b1;
                  @(negedge clk);
                  checks++;
                  if (out_ready || out_result != held ||
                      {flag_underflow, flag_overflow, flag_inexact, flag_exception, flag_invalid} != exp_fl) begin
                    errors++;
                    $display("FAIL R1 hold: actual %h rdy %b, expected %h rdy 0",
                             out_result, out_ready, held);
                  end
                end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule